// File: doc/BRIEF.md
# Multi-Channel Logic Self-Test Controller

This block runs a built-in self-test over a set of parallel scan channels that wrap a piece of logic under test. One linear-feedback pattern generator drives every channel at once. Bits leave the channels on the same shift cycles that load new bits, and a multiple-input signature register compresses them. The controller first flushes the channels to zero and loads both registers with known values. It then repeats a fixed number of load/unload shift blocks, with one capture cycle after each block. After the last capture it shifts the response out once more and compares the final signature with a golden value applied on an input.

Integration is simple. The channels and the logic under test sit outside the block. They shift on `shift_en`, take one functional clock on `capture_en`, and hold their primary inputs and outputs fixed while `isolate` is high, which keeps the signature repeatable. A single `start` pulse begins a run. `done` and `pass` report the verdict until the next run.

Top module: `lbist_ctrl`

## Requirements
- R1: After synchronous reset, `shift_en`, `capture_en`, `isolate`, `done` and `pass` are all 0.
- R2: When `start` is seen high in the idle or done state, `isolate` is 1 on exactly CH_LEN*(NUM_PAT+2)+NUM_PAT+1 consecutive cycles (all flush, shift, capture and compare cycles) and is 0 otherwise.
- R3: The first CH_LEN shift cycles of a run are a flush: `chan_in` is all zeros. The result therefore does not depend on what the channels held before the run.
- R4: On every later shift cycle, `chan_in[i]` equals bit i of the 8-bit pattern register. That register is set to PRPG_SEED (8'h01) by `start`. After each such cycle it shifts left by one, and bit 0 takes the XOR of the bits selected by PRPG_TAPS (8'hB8).
- R5: The signature register is cleared by `start` and is unchanged during the flush. On every later shift cycle it becomes {sig[6:0], ^(sig & MISR_TAPS)} XOR the channel outputs placed in bits NUM_CH-1:0, with MISR_TAPS = 8'h8E.
- R6: After the flush come NUM_PAT blocks, each of CH_LEN shift cycles followed by one capture cycle, and then CH_LEN unload shift cycles. A run has CH_LEN*(NUM_PAT+2) shift cycles and NUM_PAT capture cycles, and `shift_en` and `capture_en` are never high together.
- R7: One cycle after the last unload shift, `done` rises and `pass` shows whether the signature equals `golden_sig`. Both hold until the next accepted `start`.
- R8: A `start` pulse during a run is ignored: the cycle counts and the verdict are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle or done |
| golden_sig | input | MISR_W | Expected final signature |
| chan_out | input | NUM_CH | Serial outputs of the scan channels |
| chan_in | output | NUM_CH | Serial inputs to the scan channels |
| shift_en | output | 1 | Channel shift enable |
| capture_en | output | 1 | Capture clock enable for the logic under test |
| isolate | output | 1 | Hold the primary I/O of the logic under test |
| done | output | 1 | Run finished |
| pass | output | 1 | Final signature matched `golden_sig` |

## Verification
The assertions check on every cycle that shift and capture never overlap and that each capture is followed by a shift. They also check that channel activity only happens under isolation, that the signature stays frozen when no shift is enabled, and that the verdict holds once `done` is set. Only the bench scenarios can show the values themselves. It compares the pattern stream against an independent generator model and the verdict against a signature computed from a behavioural model of the channels and the logic under test. It confirms that a wrong golden value fails, that the stale contents of the channels are flushed away, and that a stray `start` pulse does not disturb a run.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FLUSH  = 3'd1,
    ST_LOAD   = 3'd2,
    ST_CAPT   = 3'd3,
    ST_UNLOAD = 3'd4,
    ST_CMP    = 3'd5,
    ST_DONE   = 3'd6
  } seq_state_t;
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
  parameter int              W    = 8,
  parameter int              NOUT = 4,
  parameter logic [W-1:0]    TAPS = 8'hB8,
  parameter logic [W-1:0]    SEED = 8'h01
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            adv,
  output logic [NOUT-1:0] taps_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst || load) state_q <= SEED;
    else if (adv)    state_q <= {state_q[W-2:0], fb};
  end

  genvar gi;
  generate
    for (gi = 0; gi < NOUT; gi++) begin : g_tap
      assign taps_o[gi] = state_q[gi];
    end
  endgenerate

  // generator must never reach the all-zero lock-up state
  a_r4_nonzero: assert property (@(posedge clk) disable iff (rst)
    adv |=> (state_q != '0));
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int           W    = 8,
  parameter int           NIN  = 4,
  parameter logic [W-1:0] TAPS = 8'h8E
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           en,
  input  logic [NIN-1:0] din,
  output logic [W-1:0]   sig
);
  localparam int PAD = W - NIN;

  logic [W-1:0] shifted;
  logic [W-1:0] inject;

  assign shifted = {sig[W-2:0], ^(sig & TAPS)};

  generate
    if (PAD > 0) begin : g_pad
      assign inject = {{PAD{1'b0}}, din};
    end else begin : g_nopad
      assign inject = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) sig <= '0;
    else if (en)    sig <= shifted ^ inject;
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(sig));
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int CH_LEN  = 8,
  parameter int NUM_PAT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic shift_en,
  output logic capture_en,
  output logic isolate,
  output logic flush,
  output logic adv,
  output logic cmp
);
  localparam int CW = (CH_LEN > 1) ? $clog2(CH_LEN) : 1;
  localparam int PW = $clog2(NUM_PAT + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(CH_LEN - 1);
  localparam logic [PW-1:0] LAST_PAT = PW'(NUM_PAT - 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pat_q, pat_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pat_d   = pat_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_FLUSH;
          cnt_d   = '0;
          pat_d   = '0;
          accept  = 1'b1;
        end
      end
      ST_FLUSH: begin
        if (cnt_q == LAST_BIT) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_LOAD: begin
        if (cnt_q == LAST_BIT) begin
          state_d = ST_CAPT;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_CAPT: begin
        if (pat_q == LAST_PAT) state_d = ST_UNLOAD;
        else begin
          state_d = ST_LOAD;
          pat_d   = pat_q + 1'b1;
        end
      end
      ST_UNLOAD: begin
        if (cnt_q == LAST_BIT) begin
          state_d = ST_CMP;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_CMP:  state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      pat_q      <= '0;
      shift_en   <= 1'b0;
      capture_en <= 1'b0;
      isolate    <= 1'b0;
      flush      <= 1'b0;
      adv        <= 1'b0;
      cmp        <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      pat_q      <= pat_d;
      shift_en   <= (state_d == ST_FLUSH) || (state_d == ST_LOAD) || (state_d == ST_UNLOAD);
      capture_en <= (state_d == ST_CAPT);
      isolate    <= (state_d != ST_IDLE) && (state_d != ST_DONE);
      flush      <= (state_d == ST_FLUSH);
      adv        <= (state_d == ST_LOAD) || (state_d == ST_UNLOAD);
      cmp        <= (state_d == ST_CMP);
    end
  end

  initial a_cfg_len_cap: assert (CH_LEN >= 2 && CH_LEN <= 512 && NUM_PAT >= 1);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(shift_en && capture_en));
  a_r6_capt_then_shift: assert property (@(posedge clk) disable iff (rst)
    capture_en |=> shift_en);
  a_r2_iso_cover: assert property (@(posedge clk) disable iff (rst)
    (shift_en || capture_en || cmp) |-> isolate);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (isolate && !cmp) |=> isolate);
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl #(
  parameter int            NUM_CH    = 4,
  parameter int            CH_LEN    = 8,
  parameter int            NUM_PAT   = 5,
  parameter int            PRPG_W    = 8,
  parameter int            MISR_W    = 8,
  parameter logic [7:0]    PRPG_TAPS = 8'hB8,
  parameter logic [7:0]    PRPG_SEED = 8'h01,
  parameter logic [7:0]    MISR_TAPS = 8'h8E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MISR_W-1:0] golden_sig,
  input  logic [NUM_CH-1:0] chan_out,
  output logic [NUM_CH-1:0] chan_in,
  output logic              shift_en,
  output logic              capture_en,
  output logic              isolate,
  output logic              done,
  output logic              pass
);
  logic              accept, flush, adv, cmp;
  logic [NUM_CH-1:0] gen_bits;
  logic [MISR_W-1:0] sig;

  lbist_seq #(.CH_LEN(CH_LEN), .NUM_PAT(NUM_PAT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .accept(accept),
    .shift_en(shift_en), .capture_en(capture_en), .isolate(isolate),
    .flush(flush), .adv(adv), .cmp(cmp)
  );

  lbist_prpg #(.W(PRPG_W), .NOUT(NUM_CH), .TAPS(PRPG_W'(PRPG_TAPS)),
               .SEED(PRPG_W'(PRPG_SEED))) u_prpg (
    .clk(clk), .rst(rst), .load(accept), .adv(adv), .taps_o(gen_bits)
  );

  lbist_misr #(.W(MISR_W), .NIN(NUM_CH), .TAPS(MISR_W'(MISR_TAPS))) u_misr (
    .clk(clk), .rst(rst), .clr(accept), .en(adv), .din(chan_out), .sig(sig)
  );

  assign chan_in = flush ? '0 : gen_bits;

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else if (cmp) begin
      done <= 1'b1;
      pass <= (sig == golden_sig);
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass)));
  a_r7_pass_gated: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);
endmodule

// File: tb/lbist_ctrl_bench.sv
module lbist_ctrl_bench;
  localparam int NUM_CH  = 4;
  localparam int CH_LEN  = 8;
  localparam int NUM_PAT = 5;
  localparam logic [7:0] PTAPS = 8'hB8;
  localparam logic [7:0] PSEED = 8'h01;
  localparam logic [7:0] MTAPS = 8'h8E;
  localparam int EXP_SHIFT = CH_LEN * (NUM_PAT + 2);
  localparam int EXP_ISO   = CH_LEN * (NUM_PAT + 2) + NUM_PAT + 1;

  typedef logic [NUM_CH-1:0][CH_LEN-1:0] chans_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [7:0]        golden = 8'h00;
  logic [NUM_CH-1:0] chan_out, chan_in;
  logic              shift_en, capture_en, isolate, done, pass;
  chans_t            chans = '1;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lbist_ctrl #(.NUM_CH(NUM_CH), .CH_LEN(CH_LEN), .NUM_PAT(NUM_PAT)) u_lbist_ctrl (
    .clk(clk), .rst(rst), .start(start), .golden_sig(golden),
    .chan_out(chan_out), .chan_in(chan_in), .shift_en(shift_en),
    .capture_en(capture_en), .isolate(isolate), .done(done), .pass(pass)
  );

  // model of the logic under test: one capture clock
  function automatic chans_t capf(chans_t c);
    chans_t r;
    for (int i = 0; i < NUM_CH; i++)
      r[i] = {c[i][CH_LEN-2:0], c[i][CH_LEN-1]} ^ c[(i+1)%NUM_CH] ^ CH_LEN'(i+3);
    return r;
  endfunction

  function automatic logic [7:0] pstep(logic [7:0] p);
    return {p[6:0], ^(p & PTAPS)};
  endfunction

  function automatic logic [7:0] mstep(logic [7:0] m, logic [NUM_CH-1:0] d);
    return {m[6:0], ^(m & MTAPS)} ^ {{(8-NUM_CH){1'b0}}, d};
  endfunction

  function automatic logic [7:0] expected_sig();
    chans_t c = '0;
    logic [7:0] p = PSEED;
    logic [7:0] m = 8'h00;
    logic [NUM_CH-1:0] o;
    for (int b = 0; b <= NUM_PAT; b++) begin
      for (int k = 0; k < CH_LEN; k++) begin
        for (int i = 0; i < NUM_CH; i++) o[i] = c[i][CH_LEN-1];
        m = mstep(m, o);
        for (int i = 0; i < NUM_CH; i++) c[i] = {c[i][CH_LEN-2:0], p[i]};
        p = pstep(p);
      end
      if (b < NUM_PAT) c = capf(c);
    end
    return m;
  endfunction

  // channel environment
  always @(posedge clk) begin
    if (shift_en) begin
      for (int i = 0; i < NUM_CH; i++) chans[i] <= {chans[i][CH_LEN-2:0], chan_in[i]};
    end else if (capture_en) begin
      chans <= capf(chans);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) chan_out[i] = chans[i][CH_LEN-1];
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_once(input logic [7:0] gold, input bit poke,
                          output bit fin, output bit p, output int nsh,
                          output int ncap, output int niso, output int nbad);
    logic [7:0] mp = PSEED;
    int idx = 0;
    fin = 0; nsh = 0; ncap = 0; niso = 0; nbad = 0;
    @(negedge clk); golden = gold; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      if (done) begin fin = 1; break; end
      if (isolate) niso++;
      if (capture_en) ncap++;
      if (shift_en) begin
        nsh++;
        if (idx < CH_LEN) begin
          if (chan_in != '0) nbad++;
        end else begin
          if (chan_in != mp[NUM_CH-1:0]) nbad++;
          mp = pstep(mp);
        end
        idx++;
      end
      start = (poke && cyc == 20);
      @(negedge clk);
    end
    start = 1'b0;
    p = pass;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 shift_en", int'(shift_en), 0);
    check("R1 capture_en", int'(capture_en), 0);
    check("R1 isolate", int'(isolate), 0);
    check("R1 done", int'(done), 0);
    check("R1 pass", int'(pass), 0);
  endtask

  task automatic t_good_run();
    bit f, p; int ns, nc, ni, nb;
    run_once(expected_sig(), 0, f, p, ns, nc, ni, nb);
    check("R7 done", int'(f), 1);
    check("R5 R7 pass with golden", int'(p), 1);
    check("R6 shift count", ns, EXP_SHIFT);
    check("R6 capture count", nc, NUM_PAT);
    check("R2 isolate cycles", ni, EXP_ISO);
    check("R3 R4 chan_in stream", nb, 0);
    repeat (5) @(negedge clk);
    check("R7 done held", int'(done), 1);
    check("R7 pass held", int'(pass), 1);
    check("R2 isolate low after", int'(isolate), 0);
  endtask

  task automatic t_bad_golden();
    bit f, p; int ns, nc, ni, nb;
    run_once(expected_sig() ^ 8'h10, 0, f, p, ns, nc, ni, nb);
    check("R7 done on mismatch", int'(f), 1);
    check("R7 pass low on mismatch", int'(p), 0);
  endtask

  task automatic t_start_ignored();
    bit f, p; int ns, nc, ni, nb;
    run_once(expected_sig(), 1, f, p, ns, nc, ni, nb);
    check("R8 pass", int'(p), 1);
    check("R8 shift count", ns, EXP_SHIFT);
    check("R8 isolate cycles", ni, EXP_ISO);
  endtask

  task automatic t_stale_channels();
    bit f, p; int ns, nc, ni, nb;
    // channels still hold leftovers of the previous run
    run_once(expected_sig(), 0, f, p, ns, nc, ni, nb);
    check("R3 repeatable pass", int'(p), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_good_run();
    t_bad_golden();
    t_start_ignored();
    t_stale_channels();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end
endmodule